// File: doc/BRIEF.md
# Serial SAR Converter Interface Model

This block is the digital face of a 12-bit serial sampling converter, built as synthesizable logic. A host drives an active-low chip select and a serial clock. When chip select falls, the block captures a word from a parallel port that stands in for the analog front end. It then sends a 16-bit frame, four zero bits followed by the 12 sample bits with the most significant bit first, one bit per falling serial-clock edge. The frame goes out on a serial data line with a separate drive-enable, so the pad can be tri-stated.

Where the host releases chip select inside a frame decides what happens next. A release that comes before the acquisition point makes the following frame invalid. A release between the 2nd and 9th falling edges puts the block into a low-power state. The next frame after that is a wake-up dummy frame, which carries no valid data. Both serial inputs are oversampled by a faster system clock. Two timers count in system-clock cycles: one for the quiet gap the block needs after its output is released, and one for the wake-up interval. A chip-select fall that comes too early raises a protocol-violation flag for that frame.

Top module: `sar_serial_if`

## Requirements
- R1: While reset is held and after it is released, sdo_en, sdo, pwr_down, data_valid and proto_err are all 0.
- R2: A chip-select fall drives the output (sdo_en=1) with the first leading zero on sdo. The sample is taken at that fall, so later changes on sample_in have no effect on the frame.
- R3: After falling serial-clock edge k (k=1..15), sdo_en stays 1. sdo is 0 for k<4 and sample bit 15-k for k=4..15, which puts the MSB (bit 11) after edge 4 and bit 0 after edge 15.
- R4: The 16th falling edge releases the output (sdo_en=0). Further falling edges while chip select stays low leave it released.
- R5: A chip-select rise before the 16th falling edge aborts the frame and releases the output.
- R6: A chip-select rise after 2 to 9 falling edges of a frame sets pwr_down=1. A rise after 0, 1 or 10 or more edges leaves pwr_down unchanged.
- R7: A frame reports data_valid=1 only if, in the frame before it, chip select stayed low up to a rising serial-clock edge that follows the 13th falling edge. A frame aborted at 10 to 13 edges without that rising edge makes the next frame invalid, although the block stays powered.
- R8: The first frame after reset reports data_valid=0.
- R9: A frame started while pwr_down=1 is a dummy frame with data_valid=0. pwr_down clears on its 10th falling edge. The frame after a dummy of at least 10 edges is valid, provided no timing violation occurs.
- R10: A chip-select fall less than QUIET_NS after the output is released sets proto_err=1 and data_valid=0 for that frame.
- R11: A chip-select fall less than WAKE_NS after the start of a dummy frame sets proto_err=1 and data_valid=0 for that frame.
- R12: data_valid and proto_err change only at a chip-select fall and hold their values until the next fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial inputs |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low chip select from the host |
| sclk | input | 1 | Serial clock from the host, idles high |
| sample_in | input | DATA_W | Parallel word standing in for the analog sample |
| sdo | output | 1 | Serial data out, 0 while not driven |
| sdo_en | output | 1 | Drive enable for the serial data pad |
| pwr_down | output | 1 | Block is in the low-power state |
| data_valid | output | 1 | The current frame carries a valid sample |
| proto_err | output | 1 | The current frame started in violation of quiet or wake-up timing |

## Verification
Frames are sent with all-ones, all-zeros, alternating and random sample words, and sample_in is changed after each capture. This separates a correct capture at the chip-select fall from a live pass-through, and shows up a shift-order or bit-offset error. The point of chip-select release is swept over 0 to 18 falling edges, with and without the rising edge after the 13th fall. That sweep tells the power-down window, the acquisition point and the end-of-frame release apart at their exact boundaries (1 against 2, 9 against 10, 13 with and without the rising edge). Directed back-to-back chip-select pulses and a fast dummy frame separate the quiet-time violation from the wake-up violation.

// File: rtl/sar_if_pkg.sv
// Shared constants for the serial SAR converter interface model.
// Assumes a frame of LEAD_W zero bits followed by the sample word.
package sar_if_pkg;
    localparam int LEAD_W    = 4;   // leading zero bits per frame
    localparam int PD_FIRST  = 2;   // first edge count that enters low power on release
    localparam int PD_LAST   = 9;   // last edge count that enters low power on release
    localparam int WAKE_EDGE = 10;  // edge count of a dummy frame that leaves low power
    localparam int ACQ_BACK  = 3;   // acquisition armed this many edges before frame end
endpackage

// File: rtl/sar_if_sync.sv
// Two-stage synchronizer with edge detection for N asynchronous inputs.
// Assumes each input level is held for at least two system clock cycles.
// An edge pulse lasts one cycle and appears two cycles after the input change.
module sar_if_sync #(
    parameter int           N       = 2,
    parameter logic [N-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic s1, s2, s3;
        // Purpose: resynchronize one input and keep its previous level.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s1 <= RST_VAL[i];
                s2 <= RST_VAL[i];
                s3 <= RST_VAL[i];
            end else begin
                s1 <= din[i];
                s2 <= s1;
                s3 <= s2;
            end
        end
        assign rise[i] = s2 & ~s3;
        assign fall[i] = ~s2 & s3;
    end
endmodule

// File: rtl/sar_if_timer.sv
// Reloadable down-counter: busy for LOAD cycles after a load pulse.
// Assumes LOAD >= 1.
module sar_if_timer #(
    parameter int LOAD = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic busy
);
    localparam int W = (LOAD < 2) ? 1 : $clog2(LOAD + 1);
    logic [W-1:0] count;

    // Purpose: reload on request, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (load)
            count <= W'(LOAD);
        else if (count != '0)
            count <= count - 1'b1;
    end

    assign busy = (count != '0);
endmodule

// File: rtl/sar_if_frame.sv
// Frame controller: counts falling serial-clock edges, shifts out the frame,
// and decides abort, acquisition, low-power entry and exit, and validity.
// Assumes the edge pulses come from sar_if_sync, and that a chip-select edge
// and a serial-clock edge never arrive in the same cycle.
module sar_if_frame
    import sar_if_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_fall,
    input  logic              cs_rise,
    input  logic              sclk_fall,
    input  logic              sclk_rise,
    input  logic [DATA_W-1:0] sample,
    input  logic              quiet_busy,
    input  logic              wake_busy,
    output logic              sdo,
    output logic              sdo_en,
    output logic              pwr_down,
    output logic              data_valid,
    output logic              proto_err,
    output logic              hiz_evt,
    output logic              wake_start
);
    localparam int FRAME_W = LEAD_W + DATA_W;
    localparam int CNT_W   = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0] C_END  = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] C_ACQ  = CNT_W'(FRAME_W - ACQ_BACK);
    localparam logic [CNT_W-1:0] C_WAKE = CNT_W'(WAKE_EDGE);
    localparam logic [CNT_W-1:0] C_PD_A = CNT_W'(PD_FIRST);
    localparam logic [CNT_W-1:0] C_PD_B = CNT_W'(PD_LAST);

    logic               active;
    logic [CNT_W-1:0]   cnt;
    logic [CNT_W-1:0]   cnt_inc;
    logic [FRAME_W-1:0] shreg;
    logic               acq_ok;
    logic               valid_next;
    logic               dummy;
    logic               pd_window;

    assign cnt_inc   = cnt + 1'b1;
    assign pd_window = (cnt >= C_PD_A) && (cnt <= C_PD_B);

    // Purpose: frame sequencing, power state and per-frame status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active     <= 1'b0;
            cnt        <= '0;
            shreg      <= '0;
            acq_ok     <= 1'b0;
            valid_next <= 1'b0;
            dummy      <= 1'b0;
            pwr_down   <= 1'b0;
            data_valid <= 1'b0;
            proto_err  <= 1'b0;
        end else if (cs_fall) begin
            active     <= 1'b1;
            cnt        <= '0;
            shreg      <= {{LEAD_W{1'b0}}, sample};
            acq_ok     <= 1'b0;
            dummy      <= pwr_down;
            proto_err  <= quiet_busy | wake_busy;
            data_valid <= valid_next & ~pwr_down & ~quiet_busy & ~wake_busy;
        end else if (cs_rise) begin
            active     <= 1'b0;
            if (pd_window)
                pwr_down <= 1'b1;
            valid_next <= dummy ? (cnt >= C_WAKE) : acq_ok;
        end else begin
            if (sclk_fall && active) begin
                cnt   <= cnt_inc;
                shreg <= {shreg[FRAME_W-2:0], 1'b0};
                if (cnt_inc == C_END)
                    active <= 1'b0;
                if (dummy && cnt_inc == C_WAKE)
                    pwr_down <= 1'b0;
            end
            if (sclk_rise && active && cnt >= C_ACQ)
                acq_ok <= 1'b1;
        end
    end

    assign sdo        = active & shreg[FRAME_W-1];
    assign sdo_en     = active;
    assign hiz_evt    = active & (cs_rise | (sclk_fall & (cnt_inc == C_END)));
    assign wake_start = cs_fall & pwr_down;
endmodule

// File: rtl/sar_serial_if.sv
// Top of the serial SAR converter interface model. It oversamples chip select
// and serial clock with the system clock, runs the frame controller, and times
// the quiet gap and the wake-up interval in system clock cycles.
// Assumes serial-clock levels last at least two system clock cycles.
module sar_serial_if #(
    parameter int DATA_W   = 12,
    parameter int CLK_MHZ  = 100,
    parameter int WAKE_NS  = 1000,
    parameter int QUIET_NS = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic [DATA_W-1:0] sample_in,
    output logic              sdo,
    output logic              sdo_en,
    output logic              pwr_down,
    output logic              data_valid,
    output logic              proto_err
);
    localparam int WAKE_RAW  = (CLK_MHZ * WAKE_NS + 999) / 1000;
    localparam int QUIET_RAW = (CLK_MHZ * QUIET_NS + 999) / 1000;
    localparam int WAKE_CYC  = (WAKE_RAW < 1) ? 1 : WAKE_RAW;
    localparam int QUIET_CYC = (QUIET_RAW < 1) ? 1 : QUIET_RAW;

    logic [1:0] rise_v, fall_v;
    logic       quiet_busy, wake_busy, hiz_evt, wake_start;

    sar_if_sync #(.N(2), .RST_VAL(2'b11)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({sclk, cs_n}),
        .rise (rise_v),
        .fall (fall_v)
    );

    sar_if_timer #(.LOAD(QUIET_CYC)) u_quiet (
        .clk  (clk),
        .rst_n(rst_n),
        .load (hiz_evt),
        .busy (quiet_busy)
    );

    sar_if_timer #(.LOAD(WAKE_CYC)) u_wake (
        .clk  (clk),
        .rst_n(rst_n),
        .load (wake_start),
        .busy (wake_busy)
    );

    sar_if_frame #(.DATA_W(DATA_W)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_fall   (fall_v[0]),
        .cs_rise   (rise_v[0]),
        .sclk_fall (fall_v[1]),
        .sclk_rise (rise_v[1]),
        .sample    (sample_in),
        .quiet_busy(quiet_busy),
        .wake_busy (wake_busy),
        .sdo       (sdo),
        .sdo_en    (sdo_en),
        .pwr_down  (pwr_down),
        .data_valid(data_valid),
        .proto_err (proto_err),
        .hiz_evt   (hiz_evt),
        .wake_start(wake_start)
    );
endmodule

// File: rtl/sar_serial_if_chk.sv
// Protocol checker for sar_serial_if, attached with bind.
// Assumes the two-stage input synchronizer latency of the top module.
module sar_serial_if_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic sdo_en,
    input logic pwr_down,
    input logic data_valid,
    input logic proto_err
);
    // R5
    cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> ##3 !sdo_en);
    // R12
    valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(sdo_en) |-> $stable(data_valid));
    // R12
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(sdo_en) |-> $stable(proto_err));
    // R6
    pd_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_down) |-> $fell(sdo_en));
    // R9
    pd_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_down) |-> sdo_en);
    // R9
    dummy_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sdo_en) && pwr_down) |-> !data_valid);
    // R10
    err_excludes_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |-> !data_valid);
endmodule

bind sar_serial_if sar_serial_if_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .sdo_en    (sdo_en),
    .pwr_down  (pwr_down),
    .data_valid(data_valid),
    .proto_err (proto_err)
);

// File: tb/sim_sar_serial_if.sv
// Self-checking bench for sar_serial_if: directed corner cases followed by
// seeded random frames, compared against a bench-side frame model.
module sim_sar_serial_if;
    localparam int CLK_PERIOD = 10;
    localparam int DW         = 12;
    localparam int SETTLE     = 6;
    localparam int WD_CYCLES  = 150000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1;
    logic          sclk = 1'b1;
    logic [DW-1:0] sample_in = '0;
    logic          sdo, sdo_en, pwr_down, data_valid, proto_err;

    int n_chk = 0;
    int n_err = 0;
    bit m_pd = 0;
    bit m_vnext = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sar_serial_if u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .sclk      (sclk),
        .sample_in (sample_in),
        .sdo       (sdo),
        .sdo_en    (sdo_en),
        .pwr_down  (pwr_down),
        .data_valid(data_valid),
        .proto_err (proto_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Expected sdo after falling edge k of a frame carrying smp.
    function automatic logic exp_bit(input logic [DW-1:0] smp, input int k);
        if (k < 4) return 1'b0;
        return smp[DW + 3 - k];
    endfunction

    // Model: validity flag for the frame that follows one of n edges.
    function automatic bit next_valid(input bit dummy, input int n, input bit last_rise);
        bit acq;
        acq = (n >= 14) || (n == 13 && last_rise);
        if (dummy) return (n >= 10);
        if (n >= 2 && n <= 9) return 1'b0;
        return acq;
    endfunction

    task automatic do_frame(input logic [DW-1:0] smp, input int nf, input bit last_rise,
                            input int half, input bit chk_bits, input bit ee,
                            input bit hold_hi, input string err_tag);
        bit ev, dummy;
        int n;
        dummy = m_pd;
        ev = m_vnext && !m_pd && !ee;
        sample_in = smp;
        @(negedge clk);
        cs_n = 1'b0;
        wait_n(SETTLE);
        chk("R2 sdo_en at cs fall", sdo_en, 1);
        chk("R2 first leading zero", sdo, 0);
        chk(dummy ? "R9 dummy invalid" : "R7 R8 data_valid", data_valid, ev);
        chk(err_tag, proto_err, ee);
        sample_in = DW'($urandom);  // R2: must not disturb the frame
        for (int k = 1; k <= nf; k++) begin
            sclk = 1'b0;
            wait_n(half);
            if (chk_bits) begin
                if (k < 16) begin
                    chk("R3 sdo_en during frame", sdo_en, 1);
                    chk("R3 R2 frame bit", sdo, exp_bit(smp, k));
                end else begin
                    chk("R4 released after edge 16", sdo_en, 0);
                end
            end
            if (k < nf || last_rise) begin
                sclk = 1'b1;
                wait_n(half);
            end
        end
        n = (nf > 16) ? 16 : nf;
        cs_n = 1'b1;
        m_vnext = next_valid(dummy, n, last_rise);
        if (dummy && n >= 10) m_pd = 1'b0;
        else if (!dummy && n >= 2 && n <= 9) m_pd = 1'b1;
        if (!hold_hi) return;
        wait_n(SETTLE);
        chk("R5 released after cs rise", sdo_en, 0);
        chk(dummy ? "R9 pwr_down" : "R6 pwr_down", pwr_down, m_pd);
        chk("R12 data_valid held", data_valid, ev);
        chk("R12 proto_err held", proto_err, ee);
        sclk = 1'b1;
        wait_n(4);
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd2718);
        wait_n(4);
        // R1: reset state while held
        chk("R1 sdo_en in reset", sdo_en, 0);
        chk("R1 pwr_down in reset", pwr_down, 0);
        rst_n = 1'b1;
        wait_n(4);
        chk("R1 sdo_en", sdo_en, 0);
        chk("R1 sdo", sdo, 0);
        chk("R1 pwr_down", pwr_down, 0);
        chk("R1 data_valid", data_valid, 0);
        chk("R1 proto_err", proto_err, 0);

        // R8: first frame after reset invalid
        do_frame(12'hA5C, 16, 1, 8, 1, 0, 1, "R10 proto_err");
        // R4: extra edges after the frame end
        do_frame(12'hFFF, 18, 1, 8, 1, 0, 1, "R10 proto_err");
        do_frame(12'h000, 16, 1, 8, 1, 0, 1, "R10 proto_err");
        // R6: release after one edge does not power down
        do_frame(12'h555, 1, 1, 8, 1, 0, 1, "R10 proto_err");
        do_frame(12'hAAA, 16, 1, 8, 1, 0, 1, "R10 proto_err");
        // R7: release at edge 13 without the following rise
        do_frame(12'h123, 13, 0, 8, 1, 0, 1, "R10 proto_err");
        do_frame(12'h456, 16, 1, 8, 1, 0, 1, "R10 proto_err");
        // R7: release at edge 13 after the following rise
        do_frame(12'h789, 13, 1, 8, 1, 0, 1, "R10 proto_err");
        // R6: release after 10 edges keeps power
        do_frame(12'hBCD, 10, 1, 8, 1, 0, 1, "R10 proto_err");
        // R10: abort, then chip select falls one cycle later
        do_frame(12'h321, 12, 1, 8, 1, 0, 0, "R10 proto_err");
        do_frame(12'h654, 16, 1, 8, 1, 1, 1, "R10 quiet violation");
        do_frame(12'h987, 16, 1, 8, 1, 0, 1, "R10 proto_err");
        // R6: release after 2 edges powers down; R9 dummy wakes it
        do_frame(12'hF0F, 2, 1, 8, 1, 0, 1, "R10 proto_err");
        do_frame(12'h0F0, 16, 1, 8, 1, 0, 1, "R11 proto_err");
        do_frame(12'h3C3, 9, 1, 8, 1, 0, 1, "R11 proto_err");
        // R11: short dummy, then a chip-select fall inside the wake time
        do_frame(12'hC3C, 10, 1, 2, 0, 0, 1, "R11 proto_err");
        do_frame(12'h5A5, 16, 1, 8, 1, 1, 1, "R11 wake violation");
        do_frame(12'hA5A, 16, 1, 8, 1, 0, 1, "R11 proto_err");

        // Random frames
        for (int i = 0; i < 40; i++) begin
            int nf;
            bit lr;
            nf = m_pd ? 10 + int'($urandom % 9) : int'($urandom % 19);
            lr = bit'($urandom % 2);
            do_frame(DW'($urandom), nf, lr, 8, 1, 0, 1, "R10 R11 proto_err");
        end
        finish_run();
    end
endmodule